// File: doc/BRIEF.md
# Integer Execute Unit with Loop Condition

This block is the integer execute stage of a small RISC pipeline. It takes one decoded operation per cycle, together with two 32-bit source operands, and produces the arithmetic or logical result. It keeps two single-bit condition registers, a condition code and a loop condition, and resolves the conditional branches that test them.

Subtraction always takes the second operand away from the first. Every logical operation flags a zero result. A combined add-and-branch operation supports countdown loops. It branches on the loop condition as it stands, writes the sum, and derives the next loop condition from the sign of the first operand and the sign of the sum. Fetch, the register file, memory access, delay slots and floating point are handled elsewhere.

The condition registers are the only state. The block has two condition-driven situations and no other states. In the hold situation, no valid operation arrives and both bits keep their values. In the update situation, a valid operation moves CC, LCC or neither, according to its class.

Top module: `ialu_exec`

## Requirements
- R1: While `rst_n` is low, both `cc` and `lcc` clear to 0. After release, a branch-on-CC reports not taken.
- R2: ADDU (code 1) and ADDS (code 2) output `src1+src2` modulo 2^32. ADDU sets CC to the carry out of bit 31. ADDS sets CC when the exact, unwrapped signed sum is negative.
- R3: SUBU (code 3) and SUBS (code 4) output `src1-src2` modulo 2^32. CC is set when src1 < src2. SUBU compares unsigned and SUBS compares signed.
- R4: AND (5) outputs src1&src2. ANDNOT (7) outputs src2&~src1. OR (9) outputs src1|src2. XOR (11) outputs src1^src2. Each sets CC to 1 exactly when its result is zero.
- R5: The high-half forms ANDH (6), ANDNOTH (8), ORH (10) and XORH (12) use `src2[15:0]` shifted into bits 31:16, with zeros below, in place of src2. Their CC rule is the same zero test as R4.
- R6: BC (13) reports taken when CC is 1, and BNC (14) reports taken when CC is 0. In both cases `taken` is combinational from CC before the instruction. The branch changes neither CC nor LCC, and drives `result` 0 with `res_we` low.
- R7: BLA (15) reports `taken` equal to LCC before the instruction. It outputs `src1+src2` with `res_we` high and leaves CC unchanged.
- R8: For BLA with src1 negative (bit 31 = 1), the new LCC is 1 when bit 31 of the 32-bit sum is 0.
- R9: For BLA with src1 non-negative, the new LCC is 1 when bit 31 of the 32-bit sum is 1.
- R10: With `op_valid` low, CC and LCC hold, `taken` is 0 and `res_we` is 0. NOP (code 0) writes nothing and holds both bits.
- R11: A zero-test loop exits once its counter reaches zero. The loop does XOR with zero, then BNC back while not taken-out, with an ADDU of all-ones as the decrement.
- R12: Arithmetic and logical operations drive `res_we` high, and they leave LCC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op | input | 4 | Decoded operation code |
| src1 | input | 32 | First source operand |
| src2 | input | 32 | Second source operand |
| result | output | 32 | Computed result |
| res_we | output | 1 | Result should be written to the destination |
| cc | output | 1 | Current condition code |
| lcc | output | 1 | Current loop condition |
| taken | output | 1 | Branch resolved as taken |

## Verification
BLA is the case where two functions share one cycle. It resolves the branch from the old LCC and, in the same cycle, computes the next LCC from the new sum. A run of back-to-back BLA operations, each with a negative src1 and a shrinking src2, therefore checks `taken` against the previous vector's LCC. The registered LCC is checked against the current sum after the edge. The same runs confirm that CC stays put while LCC moves, and that a BC placed right after a CC-setting operation sees the new CC in its own cycle.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_ADDU    = 4'd1,
        OP_ADDS    = 4'd2,
        OP_SUBU    = 4'd3,
        OP_SUBS    = 4'd4,
        OP_AND     = 4'd5,
        OP_ANDH    = 4'd6,
        OP_ANDNOT  = 4'd7,
        OP_ANDNOTH = 4'd8,
        OP_OR      = 4'd9,
        OP_ORH     = 4'd10,
        OP_XOR     = 4'd11,
        OP_XORH    = 4'd12,
        OP_BC      = 4'd13,
        OP_BNC     = 4'd14,
        OP_BLA     = 4'd15
    } ialu_op_e;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_ARITH,
        CLS_LOGIC,
        CLS_LOOP
    } ialu_cls_e;

    function automatic ialu_cls_e op_class(input ialu_op_e o);
        unique case (o)
            OP_ADDU, OP_ADDS, OP_SUBU, OP_SUBS:           return CLS_ARITH;
            OP_AND, OP_ANDH, OP_ANDNOT, OP_ANDNOTH,
            OP_OR, OP_ORH, OP_XOR, OP_XORH:               return CLS_LOGIC;
            OP_BLA:                                        return CLS_LOOP;
            default:                                       return CLS_NONE;
        endcase
    endfunction
endpackage

// File: rtl/ialu_arith.sv
module ialu_arith
    import ialu_pkg::*;
#(
    parameter int W = 32
) (
    input  ialu_op_e     op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         flag
);
    logic [W:0] uadd;
    logic [W:0] sadd;
    logic       ult;
    logic       slt;

    always_comb begin
        uadd = {1'b0, a} + {1'b0, b};
        sadd = {a[W-1], a} + {b[W-1], b};
        ult  = (a < b);
        slt  = ($signed(a) < $signed(b));
        res  = '0;
        flag = 1'b0;
        unique case (op)
            OP_ADDU: begin res = uadd[W-1:0]; flag = uadd[W]; end
            OP_ADDS: begin res = uadd[W-1:0]; flag = sadd[W]; end
            OP_SUBU: begin res = a - b;       flag = ult;     end
            OP_SUBS: begin res = a - b;       flag = slt;     end
            default: begin res = '0;          flag = 1'b0;    end
        endcase
    end
endmodule

// File: rtl/ialu_logic.sv
module ialu_logic
    import ialu_pkg::*;
#(
    parameter int W = 32
) (
    input  ialu_op_e     op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         zero
);
    localparam int HALF = W / 2;

    logic [W-1:0] b_hi;
    logic [W-1:0] opnd;
    logic         use_hi;

    generate
        if (HALF > 0) begin : g_hi
            assign b_hi = {b[HALF-1:0], {(W-HALF){1'b0}}};
        end else begin : g_nohi
            assign b_hi = b;
        end
    endgenerate

    always_comb begin
        use_hi = (op == OP_ANDH) || (op == OP_ANDNOTH) ||
                 (op == OP_ORH)  || (op == OP_XORH);
        opnd   = use_hi ? b_hi : b;
        unique case (op)
            OP_AND, OP_ANDH:       res = a & opnd;
            OP_ANDNOT, OP_ANDNOTH: res = opnd & ~a;
            OP_OR, OP_ORH:         res = a | opnd;
            OP_XOR, OP_XORH:       res = a ^ opnd;
            default:               res = '0;
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/ialu_loop.sv
module ialu_loop
    import ialu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         valid,
    input  ialu_op_e     op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cc_now,
    input  logic         lcc_now,
    output logic [W-1:0] sum,
    output logic         lcc_new,
    output logic         taken
);
    always_comb begin
        sum     = a + b;
        // Sign-dependent rule: negative step waits for the sum to cross back to >= 0.
        lcc_new = a[W-1] ? ~sum[W-1] : sum[W-1];
        taken   = 1'b0;
        if (valid) begin
            unique case (op)
                OP_BC:   taken = cc_now;
                OP_BNC:  taken = ~cc_now;
                OP_BLA:  taken = lcc_now;
                default: taken = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
    import ialu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op,
    input  logic [W-1:0] src1,
    input  logic [W-1:0] src2,
    output logic [W-1:0] result,
    output logic         res_we,
    output logic         cc,
    output logic         lcc,
    output logic         taken
);
    ialu_op_e     op_e;
    ialu_cls_e    cls;
    logic [W-1:0] ar_res, lg_res, lp_sum;
    logic         ar_flag, lg_zero, lp_lcc;
    logic         cc_q, lcc_q, cc_d, lcc_d;

    assign op_e = ialu_op_e'(op);

    ialu_arith #(.W(W)) u_arith (.op(op_e), .a(src1), .b(src2), .res(ar_res), .flag(ar_flag));
    ialu_logic #(.W(W)) u_logic (.op(op_e), .a(src1), .b(src2), .res(lg_res), .zero(lg_zero));
    ialu_loop  #(.W(W)) u_loop  (.valid(op_valid), .op(op_e), .a(src1), .b(src2),
                                 .cc_now(cc_q), .lcc_now(lcc_q),
                                 .sum(lp_sum), .lcc_new(lp_lcc), .taken(taken));

    // next-state and result selection
    always_comb begin
        cls    = op_valid ? op_class(op_e) : CLS_NONE;
        cc_d   = cc_q;
        lcc_d  = lcc_q;
        result = '0;
        res_we = 1'b0;
        unique case (cls)
            CLS_ARITH: begin cc_d = ar_flag; result = ar_res; res_we = 1'b1; end
            CLS_LOGIC: begin cc_d = lg_zero; result = lg_res; res_we = 1'b1; end
            CLS_LOOP:  begin lcc_d = lp_lcc; result = lp_sum; res_we = 1'b1; end
            default:   begin end
        endcase
    end

    // condition register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cc_q  <= 1'b0;
            lcc_q <= 1'b0;
        end else begin
            cc_q  <= cc_d;
            lcc_q <= lcc_d;
        end
    end

    assign cc  = cc_q;
    assign lcc = lcc_q;

    AST_SUB_LESS_U: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd3) |=> (cc == ($past(src1) < $past(src2)))); // R3
    AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op >= 4'd5 && op <= 4'd12) |=> (cc == ($past(result) == '0))); // R4
    AST_BC_OLD_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd13) |-> (taken == cc && !res_we)); // R6
    AST_BLA_OLD_LCC: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd15) |-> (taken == lcc)); // R7
    AST_BLA_CC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd15) |=> (cc == $past(cc))); // R7
    AST_LCC_NEG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd15 && src1[W-1]) |=> (lcc == !$past(result[W-1]))); // R8
    AST_LCC_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd15 && !src1[W-1]) |=> (lcc == $past(result[W-1]))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(cc) && $stable(lcc))); // R10
    AST_ARITH_LCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op >= 4'd1 && op <= 4'd12) |=> $stable(lcc)); // R12
endmodule

// File: tb/test_ialu_exec.sv
module test_ialu_exec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op = 4'd0;
    logic [31:0] src1 = '0, src2 = '0;
    logic [31:0] result;
    logic        res_we, cc, lcc, taken;
    int          n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    ialu_exec i_ialu_exec (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
        .src1(src1), .src2(src2), .result(result), .res_we(res_we),
        .cc(cc), .lcc(lcc), .taken(taken));

    // {op, src1, src2, result, cc_after, lcc_after, taken}
    localparam int NV = 27;
    localparam logic [102:0] VEC [NV] = '{
        {4'd1,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R2 carry
        {4'd3,  32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0}, // R3
        {4'd3,  32'h00000005, 32'h00000003, 32'h00000002, 1'b0, 1'b0, 1'b0}, // R3
        {4'd4,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0}, // R3 signed
        {4'd3,  32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0}, // R3 unsigned
        {4'd2,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0, 1'b0}, // R2 signed
        {4'd2,  32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0}, // R2
        {4'd13, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b1}, // R6
        {4'd14, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R6
        {4'd5,  32'h0000F0F0, 32'h00000F0F, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R4
        {4'd9,  32'h00000000, 32'h00000010, 32'h00000010, 1'b0, 1'b0, 1'b0}, // R4
        {4'd13, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b0}, // R6
        {4'd14, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b0, 1'b1}, // R6
        {4'd11, 32'h5A5A5A5A, 32'h5A5A5A5A, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R4
        {4'd7,  32'h0000000F, 32'h000000FF, 32'h000000F0, 1'b0, 1'b0, 1'b0}, // R4
        {4'd6,  32'h12340000, 32'h00001234, 32'h12340000, 1'b0, 1'b0, 1'b0}, // R5
        {4'd10, 32'h00000000, 32'h0000ABCD, 32'hABCD0000, 1'b0, 1'b0, 1'b0}, // R5
        {4'd12, 32'hABCD0000, 32'h0000ABCD, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R5
        {4'd8,  32'hFFFF0000, 32'h0000FFFF, 32'h00000000, 1'b1, 1'b0, 1'b0}, // R5
        {4'd15, 32'hFFFFFFFF, 32'h00000003, 32'h00000002, 1'b1, 1'b1, 1'b0}, // R8
        {4'd15, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 1'b1, 1'b1, 1'b1}, // R8
        {4'd15, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b1, 1'b1}, // R8
        {4'd15, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1}, // R8
        {4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b1, 1'b0, 1'b0}, // R8
        {4'd15, 32'h00000001, 32'hFFFFFFFD, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0}, // R9
        {4'd15, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 1'b1, 1'b1, 1'b1}, // R9
        {4'd15, 32'h00000000, 32'h00000005, 32'h00000005, 1'b1, 1'b0, 1'b1}  // R9
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_valid = v; op = o; src1 = a; src2 = b;
        #1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int          iters;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 cc in reset", {31'd0, cc}, 32'd0);
        chk("R1 lcc in reset", {31'd0, lcc}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 4'd13, '0, '0);
        chk("R1 BC after reset", {31'd0, taken}, 32'd0);
        step();

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i][102:99], VEC[i][98:67], VEC[i][66:35]);
            chk($sformatf("vec%0d result R2-R9", i), result, VEC[i][34:3]);
            chk($sformatf("vec%0d taken R6/R7", i), {31'd0, taken}, {31'd0, VEC[i][0]});
            chk($sformatf("vec%0d res_we R6/R12", i), {31'd0, res_we},
                {31'd0, !(VEC[i][102:99] == 4'd13 || VEC[i][102:99] == 4'd14)});
            step();
            chk($sformatf("vec%0d cc R2-R7", i), {31'd0, cc}, {31'd0, VEC[i][2]});
            chk($sformatf("vec%0d lcc R8/R9/R12", i), {31'd0, lcc}, {31'd0, VEC[i][1]});
        end

        // R10: idle and NOP keep state (cc=1, lcc=0 here)
        drive(1'b0, 4'd3, 32'd5, 32'd3);
        chk("R10 taken idle", {31'd0, taken}, 32'd0);
        chk("R10 res_we idle", {31'd0, res_we}, 32'd0);
        step();
        chk("R10 cc held", {31'd0, cc}, 32'd1);
        drive(1'b0, 4'd15, 32'hFFFFFFFF, 32'd4);
        step();
        chk("R10 lcc held", {31'd0, lcc}, 32'd0);
        drive(1'b1, 4'd0, 32'd7, 32'd9);
        chk("R10 NOP res_we", {31'd0, res_we}, 32'd0);
        step();
        chk("R10 NOP cc", {31'd0, cc}, 32'd1);

        // R11: zero-test loop counting down from 3
        r = 32'd3;
        iters = 0;
        for (int k = 0; k < 10; k++) begin
            drive(1'b1, 4'd11, r, 32'd0);
            step();
            drive(1'b1, 4'd14, '0, '0);
            if (!taken) break;
            step();
            drive(1'b1, 4'd1, r, 32'hFFFFFFFF);
            r = result;
            step();
            iters++;
        end
        chk("R11 loop iterations", iters, 32'd3);
        chk("R11 cc at exit", {31'd0, cc}, 32'd1);

        drive(1'b0, 4'd0, '0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule